// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This block turns one operand specifier of a two-address instruction into something the execute stage can use directly. It yields either a register number, when the operand lives in a register, or a 16-bit effective address in memory. On the way it applies the side effects the specifier asks for. It pre-decrements or post-increments the base register, fetches a displacement that follows the instruction, advances the program counter past that word and follows one level of pointer indirection.

The specifier holds a 3-bit mode in its upper bits and a register number in its lower bits. A one-cycle `start` strobe captures the specifier together with a byte/word flag. The block reads the register file through a combinational read port and writes the stepped base back through a single write port. Memory is read through a request/ready port: the request and address are held until ready is seen. A one-cycle `done` pulse marks the result. Moving the operand data, the ALU and the rest of instruction decode are outside this block.

Top module: `opea_seq`

## Requirements
- R1: Mode 0 (register): `done` rises in the cycle after `start`, with `is_reg`=1 and `reg_num` equal to specifier bits 2:0. The operand makes no memory request and no register write.
- R2: Mode 1 (register deferred): `ea` equals the register value and the register is left unchanged. `done` rises two cycles after `start`.
- R3: Mode 2 (autoincrement): `ea` equals the register value before the step, and the register is then written with that value plus the stride.
- R4: Mode 4 (autodecrement): the register is written with its value minus the stride, and `ea` equals that decremented value. Wrap-around below zero is modulo 2^16.
- R5: For registers 0 to 5 in modes 2 and 4, the stride is 1 when `byte_op`=1 and 2 when `byte_op`=0.
- R6: Register 6 (stack pointer) and register 7 (program counter) always step by 2, even when `byte_op`=1.
- R7: Modes 3 and 5 (autoincrement/autodecrement deferred) step the register by 2 regardless of `byte_op`. They read one word at the pre-step address (mode 3) or at the post-step address (mode 5), and `ea` is the word that was read.
- R8: Mode 6 (index) reads a displacement word at the current PC and writes PC+2 to register 7. `ea` is the base register plus the displacement, and when the base is register 7 the value added is PC+2.
- R9: Mode 7 (index deferred) forms the same sum as R8 and then reads one word there. `ea` is that word.
- R10: With register 7, mode 2 yields `ea` equal to the old PC (immediate operand), and mode 3 yields `ea` equal to the word at the old PC (absolute address). Both leave PC+2 in register 7.
- R11: While `mem_req` is high and `mem_ready` is low, `mem_req` stays high and `mem_addr` is unchanged. Each read adds one cycle to the operand for every cycle that ready is withheld.
- R12: Modes 2 to 7 perform exactly one register write per operand, and modes 0 and 1 perform none.
- R13: Reset, including a reset during a pending memory read, returns the block to idle with `done`, `mem_req` and `rf_wr_en` low. The next operand then resolves normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Capture the specifier and begin (taken only when idle) |
| spec | input | 6 | Operand specifier: bits 5:3 mode, bits 2:0 register |
| byte_op | input | 1 | 1 = byte-sized operand, 0 = word |
| rf_rd_idx | output | 3 | Register file read index |
| rf_rd_data | input | 16 | Register file read data (combinational) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_idx | output | 3 | Register write index |
| rf_wr_data | output | 16 | Register write value |
| mem_req | output | 1 | Memory read request, held until ready |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 16 | Memory read data, valid with ready |
| mem_ready | input | 1 | Memory read completes this cycle |
| done | output | 1 | One-cycle pulse: result valid |
| is_reg | output | 1 | Result is a register operand |
| reg_num | output | 3 | Register number of the operand |
| ea | output | 16 | Effective address of the operand |

## Verification
A stale mode or register latch shows up at the `done` pulse as a wrong `ea` or a wrong register written back, and for register mode as a missing `is_reg`. A wrong stride value is visible in the register file one edge after the base-read cycle. A corrupted sequencer state shows up as a `done` pulse in the wrong cycle relative to `start` and the ready handshake, or as a request whose address moves while it waits. For that reason every vector also checks the exact latency, the count of register writes and the final PC.

// File: rtl/opea_pkg.sv
package opea_pkg;

   typedef enum logic [2:0] {
      AM_REG  = 3'd0,
      AM_DEF  = 3'd1,
      AM_INC  = 3'd2,
      AM_INCD = 3'd3,
      AM_DEC  = 3'd4,
      AM_DECD = 3'd5,
      AM_IDX  = 3'd6,
      AM_IDXD = 3'd7
   } am_mode_t;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_BASE = 3'd1,
      SQ_EXT  = 3'd2,
      SQ_IDX  = 3'd3,
      SQ_PTR  = 3'd4
   } sq_state_t;

   // Deferred auto-step modes address a pointer word, so their stride is fixed wide.
   function automatic logic pointer_step(input am_mode_t m);
      return (m == AM_INCD) || (m == AM_DECD);
   endfunction

endpackage

// File: rtl/opea_stride.sv
module opea_stride
   import opea_pkg::*;
#(
   parameter int AW      = 16,
   parameter int RIW     = 3,
   parameter int SP_IDX  = 6,
   parameter int PC_IDX  = 7,
   parameter bit WIDE_SP = 1'b1
) (
   input  logic [AW-1:0]  base,
   input  am_mode_t       mode,
   input  logic [RIW-1:0] regno,
   input  logic           byte_op,
   output logic [AW-1:0]  inc_val,
   output logic [AW-1:0]  dec_val
);

   localparam logic [AW-1:0] STEP_NARROW = AW'(1);
   localparam logic [AW-1:0] STEP_WIDE   = AW'(2);

   logic          wide_reg;
   logic [AW-1:0] step;

   generate
      if (WIDE_SP) begin : g_sp_wide
         assign wide_reg = (regno == RIW'(SP_IDX)) || (regno == RIW'(PC_IDX));
      end else begin : g_pc_only
         assign wide_reg = (regno == RIW'(PC_IDX));
      end
   endgenerate

   always_comb begin
      if (wide_reg || pointer_step(mode) || !byte_op) step = STEP_WIDE;
      else                                            step = STEP_NARROW;
   end

   assign inc_val = base + step;
   assign dec_val = base - step;

endmodule

// File: rtl/opea_ctrl.sv
module opea_ctrl
   import opea_pkg::*;
#(
   parameter int AW     = 16,
   parameter int RIW    = 3,
   parameter int PC_IDX = 7
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [RIW+2:0] spec,
   input  logic           byte_op,
   output logic [RIW-1:0] rf_rd_idx,
   input  logic [AW-1:0]  rf_rd_data,
   output logic           rf_wr_en,
   output logic [RIW-1:0] rf_wr_idx,
   output logic [AW-1:0]  rf_wr_data,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic [AW-1:0]  mem_rdata,
   input  logic           mem_ready,
   output logic           done,
   output logic           is_reg,
   output logic [RIW-1:0] reg_num,
   output logic [AW-1:0]  ea,
   output am_mode_t       mode_q,
   output logic [RIW-1:0] reg_q,
   output logic           byte_q,
   input  logic [AW-1:0]  inc_val,
   input  logic [AW-1:0]  dec_val
);

   localparam logic [RIW-1:0] PC_SEL   = RIW'(PC_IDX);
   localparam logic [AW-1:0]  WORD_ADV = AW'(2);

   sq_state_t     state_q;
   logic [AW-1:0] addr_q;
   logic [AW-1:0] disp_q;
   logic [AW-1:0] ea_q;
   logic          done_q;
   logic          isreg_q;
   logic [AW-1:0] idx_sum;
   am_mode_t      spec_mode;

   assign spec_mode = am_mode_t'(spec[RIW+2:RIW]);
   assign idx_sum   = rf_rd_data + disp_q;

   // The base read returns the program counter for index modes; otherwise the named register.
   assign rf_rd_idx = (state_q == SQ_BASE && (mode_q == AM_IDX || mode_q == AM_IDXD))
                      ? PC_SEL : reg_q;

   assign mem_req  = (state_q == SQ_EXT) || (state_q == SQ_PTR);
   assign mem_addr = addr_q;

   always_comb begin
      rf_wr_en   = 1'b0;
      rf_wr_idx  = reg_q;
      rf_wr_data = inc_val;
      unique case (state_q)
         SQ_BASE: begin
            if (mode_q == AM_INC || mode_q == AM_INCD) begin
               rf_wr_en   = 1'b1;
               rf_wr_data = inc_val;
            end else if (mode_q == AM_DEC || mode_q == AM_DECD) begin
               rf_wr_en   = 1'b1;
               rf_wr_data = dec_val;
            end
         end
         SQ_EXT: begin
            rf_wr_en   = mem_ready;
            rf_wr_idx  = PC_SEL;
            rf_wr_data = addr_q + WORD_ADV;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mode_q  <= AM_REG;
         reg_q   <= '0;
         byte_q  <= 1'b0;
         addr_q  <= '0;
         disp_q  <= '0;
         ea_q    <= '0;
         done_q  <= 1'b0;
         isreg_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            SQ_IDLE: begin
               if (start) begin
                  mode_q  <= spec_mode;
                  reg_q   <= spec[RIW-1:0];
                  byte_q  <= byte_op;
                  isreg_q <= (spec_mode == AM_REG);
                  if (spec_mode == AM_REG) done_q  <= 1'b1;
                  else                     state_q <= SQ_BASE;
               end
            end
            SQ_BASE: begin
               unique case (mode_q)
                  AM_DEF, AM_INC: begin
                     ea_q    <= rf_rd_data;
                     done_q  <= 1'b1;
                     state_q <= SQ_IDLE;
                  end
                  AM_DEC: begin
                     ea_q    <= dec_val;
                     done_q  <= 1'b1;
                     state_q <= SQ_IDLE;
                  end
                  AM_INCD: begin
                     addr_q  <= rf_rd_data;
                     state_q <= SQ_PTR;
                  end
                  AM_DECD: begin
                     addr_q  <= dec_val;
                     state_q <= SQ_PTR;
                  end
                  AM_IDX, AM_IDXD: begin
                     addr_q  <= rf_rd_data;
                     state_q <= SQ_EXT;
                  end
                  default: state_q <= SQ_IDLE;
               endcase
            end
            SQ_EXT: begin
               if (mem_ready) begin
                  disp_q  <= mem_rdata;
                  state_q <= SQ_IDX;
               end
            end
            SQ_IDX: begin
               if (mode_q == AM_IDX) begin
                  ea_q    <= idx_sum;
                  done_q  <= 1'b1;
                  state_q <= SQ_IDLE;
               end else begin
                  addr_q  <= idx_sum;
                  state_q <= SQ_PTR;
               end
            end
            SQ_PTR: begin
               if (mem_ready) begin
                  ea_q    <= mem_rdata;
                  done_q  <= 1'b1;
                  state_q <= SQ_IDLE;
               end
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   assign done    = done_q;
   assign is_reg  = isreg_q;
   assign reg_num = reg_q;
   assign ea      = ea_q;

   // Write-back tally for the operand in flight (checking only).
   logic [1:0] wr_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             wr_cnt_q <= 2'd0;
      else if (state_q == SQ_IDLE && start)   wr_cnt_q <= 2'd0;
      else if (rf_wr_en && wr_cnt_q != 2'd3)  wr_cnt_q <= wr_cnt_q + 2'd1;
   end

   a_r1_reg_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == SQ_IDLE && start && spec_mode == AM_REG) |=> (done && is_reg));

   a_r1_no_mem_for_reg: assert property (@(posedge clk) disable iff (!rst_n)
      is_reg |-> !mem_req);

   a_r11_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

   a_r12_one_writeback: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (wr_cnt_q == ((mode_q == AM_REG || mode_q == AM_DEF) ? 2'd0 : 2'd1)));

endmodule

// File: rtl/opea_seq.sv
module opea_seq
   import opea_pkg::*;
#(
   parameter int AW      = 16,
   parameter int NREG    = 8,
   parameter int SP_IDX  = 6,
   parameter int PC_IDX  = 7,
   parameter bit WIDE_SP = 1'b1,
   localparam int RIW    = $clog2(NREG),
   localparam int SPW    = RIW + 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic [SPW-1:0] spec,
   input  logic           byte_op,
   output logic [RIW-1:0] rf_rd_idx,
   input  logic [AW-1:0]  rf_rd_data,
   output logic           rf_wr_en,
   output logic [RIW-1:0] rf_wr_idx,
   output logic [AW-1:0]  rf_wr_data,
   output logic           mem_req,
   output logic [AW-1:0]  mem_addr,
   input  logic [AW-1:0]  mem_rdata,
   input  logic           mem_ready,
   output logic           done,
   output logic           is_reg,
   output logic [RIW-1:0] reg_num,
   output logic [AW-1:0]  ea
);

   generate
      if (AW < 4) begin : g_bad_width
         $error("opea_seq: AW must be at least 4");
      end
      if (NREG < 2 || (1 << RIW) != NREG) begin : g_bad_nreg
         $error("opea_seq: NREG must be a power of two, at least 2");
      end
      if (PC_IDX >= NREG || SP_IDX >= NREG || PC_IDX == SP_IDX) begin : g_bad_idx
         $error("opea_seq: SP_IDX and PC_IDX must be distinct registers");
      end
   endgenerate

   am_mode_t       mode_q;
   logic [RIW-1:0] reg_q;
   logic           byte_q;
   logic [AW-1:0]  inc_val;
   logic [AW-1:0]  dec_val;

   opea_stride #(
      .AW(AW), .RIW(RIW), .SP_IDX(SP_IDX), .PC_IDX(PC_IDX), .WIDE_SP(WIDE_SP)
   ) stride_i (
      .base    (rf_rd_data),
      .mode    (mode_q),
      .regno   (reg_q),
      .byte_op (byte_q),
      .inc_val (inc_val),
      .dec_val (dec_val)
   );

   opea_ctrl #(
      .AW(AW), .RIW(RIW), .PC_IDX(PC_IDX)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .spec       (spec),
      .byte_op    (byte_op),
      .rf_rd_idx  (rf_rd_idx),
      .rf_rd_data (rf_rd_data),
      .rf_wr_en   (rf_wr_en),
      .rf_wr_idx  (rf_wr_idx),
      .rf_wr_data (rf_wr_data),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .mem_rdata  (mem_rdata),
      .mem_ready  (mem_ready),
      .done       (done),
      .is_reg     (is_reg),
      .reg_num    (reg_num),
      .ea         (ea),
      .mode_q     (mode_q),
      .reg_q      (reg_q),
      .byte_q     (byte_q),
      .inc_val    (inc_val),
      .dec_val    (dec_val)
   );

endmodule

// File: tb/opea_seq_tb.sv
module opea_seq_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [5:0]  spec = '0;
   logic        byte_op = 1'b0;
   logic [2:0]  rf_rd_idx;
   logic [15:0] rf_rd_data;
   logic        rf_wr_en;
   logic [2:0]  rf_wr_idx;
   logic [15:0] rf_wr_data;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic [15:0] mem_rdata;
   logic        mem_ready = 1'b0;
   logic        done;
   logic        is_reg;
   logic [2:0]  reg_num;
   logic [15:0] ea;

   always #5 clk = ~clk;

   opea_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .done(done), .is_reg(is_reg), .reg_num(reg_num), .ea(ea)
   );

   // Register file and memory models
   logic [15:0] rf [8];
   int          wr_cnt;
   int          req_cnt;
   int          lat;
   int          wait_cnt;

   function automatic logic [15:0] memf(input logic [15:0] a);
      return {a[7:0], a[15:8]} ^ 16'h3C5A;
   endfunction

   assign rf_rd_data = rf[rf_rd_idx];
   assign mem_rdata  = memf(mem_addr);

   always @(posedge clk) begin
      if (rf_wr_en) begin
         rf[rf_wr_idx] <= rf_wr_data;
         wr_cnt <= wr_cnt + 1;
      end
      if (mem_req) req_cnt <= req_cnt + 1;
      if (mem_req && !mem_ready) begin
         mem_ready <= (wait_cnt >= lat);
         wait_cnt  <= wait_cnt + 1;
      end else begin
         mem_ready <= 1'b0;
         wait_cnt  <= 0;
      end
   end

   int checks = 0;
   int fails  = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // {spec, byte_op, reg value, pc value, ready latency}
   localparam int NV = 18;
   localparam logic [40:0] VEC [NV] = '{
      {6'o03, 1'b0, 16'h1234, 16'h0400, 2'd0},
      {6'o15, 1'b1, 16'h2000, 16'h0400, 2'd0},
      {6'o23, 1'b1, 16'h3001, 16'h0400, 2'd0},
      {6'o23, 1'b0, 16'h3001, 16'h0400, 2'd0},
      {6'o43, 1'b1, 16'h4000, 16'h0400, 2'd0},
      {6'o44, 1'b0, 16'h4000, 16'h0400, 2'd0},
      {6'o41, 1'b1, 16'h0000, 16'h0400, 2'd0},
      {6'o26, 1'b1, 16'h0F00, 16'h0400, 2'd0},
      {6'o46, 1'b1, 16'h0F00, 16'h0400, 2'd0},
      {6'o27, 1'b1, 16'h0000, 16'h0500, 2'd0},
      {6'o37, 1'b0, 16'h0000, 16'h0600, 2'd2},
      {6'o32, 1'b1, 16'h5000, 16'h0400, 2'd1},
      {6'o52, 1'b1, 16'h5000, 16'h0400, 2'd0},
      {6'o64, 1'b0, 16'h6000, 16'h0700, 2'd1},
      {6'o67, 1'b0, 16'h0000, 16'h0800, 2'd0},
      {6'o75, 1'b1, 16'h7000, 16'h0900, 2'd3},
      {6'o77, 1'b0, 16'h0000, 16'h0A00, 2'd2},
      {6'o47, 1'b1, 16'h0000, 16'h0B00, 2'd0}
   };

   task automatic preload(input logic [2:0] r, input logic [15:0] rv, input logic [15:0] pc);
      for (int i = 0; i < 8; i++) rf[i] = 16'hA000 + 16'(i * 16'h0111);
      rf[7] = pc;
      if (r != 3'd7) rf[r] = rv;
      wr_cnt  = 0;
      req_cnt = 0;
   endtask

   task automatic launch(input logic [5:0] s, input logic b, output int cyc);
      spec    = s;
      byte_op = b;
      start   = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc   = 1;
      while (!done && cyc < 60) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   function automatic string ea_tag(input logic [2:0] m, input logic [2:0] r);
      if (r == 3'd7 && (m == 3'd2 || m == 3'd3)) return "R10 ea";
      case (m)
         3'd0: return "R1 reg";
         3'd1: return "R2 ea";
         3'd2: return "R3 ea";
         3'd3: return "R7 ea";
         3'd4: return "R4 ea";
         3'd5: return "R7 ea";
         3'd6: return "R8 ea";
         default: return "R9 ea";
      endcase
   endfunction

   task automatic run_vec(input logic [40:0] v);
      logic [5:0]  s;
      logic        b;
      logic [15:0] rv, pc, r0, rn, pcn, d, base, expea;
      logic [2:0]  m, r;
      int          l, cyc, ecyc, ewr, st;
      s = v[40:35]; b = v[34]; rv = v[33:18]; pc = v[17:2]; l = int'(v[1:0]);
      m = s[5:3]; r = s[2:0];
      r0 = (r == 3'd7) ? pc : rv;
      st = (!b || r >= 3'd6 || m == 3'd3 || m == 3'd5) ? 2 : 1;
      rn = r0; pcn = pc; expea = 16'h0; ewr = 1; d = 16'h0;
      case (m)
         3'd0: begin ecyc = 1; ewr = 0; end
         3'd1: begin ecyc = 2; ewr = 0; expea = r0; end
         3'd2: begin ecyc = 2; expea = r0; rn = r0 + 16'(st); end
         3'd3: begin ecyc = 4 + l; expea = memf(r0); rn = r0 + 16'd2; end
         3'd4: begin ecyc = 2; rn = r0 - 16'(st); expea = rn; end
         3'd5: begin ecyc = 4 + l; rn = r0 - 16'd2; expea = memf(rn); end
         default: begin
            d = memf(pc);
            pcn = pc + 16'd2;
            base = (r == 3'd7) ? pcn : rv;
            if (m == 3'd6) begin ecyc = 5 + l; expea = base + d; end
            else begin ecyc = 7 + 2 * l; expea = memf(base + d); end
            if (r == 3'd7) rn = pcn;
         end
      endcase
      if (r == 3'd7 && m != 3'd6 && m != 3'd7) pcn = rn;
      lat = l;
      preload(r, rv, pc);
      @(negedge clk);
      launch(s, b, cyc);
      chk("R11 done latency", 32'(cyc), 32'(ecyc));
      chk((m == 3'd0) ? "R1 is_reg" : "R2 is_reg", {31'd0, is_reg}, {31'd0, (m == 3'd0)});
      if (m == 3'd0) chk("R1 reg_num", {29'd0, reg_num}, {29'd0, r});
      else           chk(ea_tag(m, r), {16'd0, ea}, {16'd0, expea});
      if (r != 3'd7)
         chk((r >= 3'd6) ? "R6 stride" : ((m == 3'd3 || m == 3'd5) ? "R7 stride" : "R5 stride"),
             {16'd0, rf[r]}, {16'd0, rn});
      chk((m >= 3'd6) ? "R8 pc advance" : "R10 pc", {16'd0, rf[7]}, {16'd0, pcn});
      chk("R12 writes", 32'(wr_cnt), 32'(ewr));
      if (m == 3'd0) chk("R1 no mem", 32'(req_cnt), 32'd0);
   endtask

   bit finished = 1'b0;

   initial begin
      int cyc;
      for (int i = 0; i < 8; i++) rf[i] = '0;
      wr_cnt = 0; req_cnt = 0; lat = 0; wait_cnt = 0;
      repeat (3) @(negedge clk);
      chk("R13 reset done", {31'd0, done}, 32'd0);
      chk("R13 reset req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R13 idle write", {31'd0, rf_wr_en}, 32'd0);

      for (int i = 0; i < NV; i++) run_vec(VEC[i]);

      // Reset while a pointer read is stalled
      lat = 3;
      preload(3'd2, 16'h1200, 16'h0400);
      spec = 6'o32; byte_op = 1'b0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (2) @(negedge clk);
      chk("R11 stalled req held", {31'd0, mem_req}, 32'd1);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R13 abort req", {31'd0, mem_req}, 32'd0);
      chk("R13 abort done", {31'd0, done}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      run_vec({6'o25, 1'b1, 16'h0203, 16'h0400, 2'd0});
      run_vec({6'o01, 1'b1, 16'h0000, 16'h0400, 2'd0});

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog R11 actual=hung expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

endmodule